// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Logic

This block keeps the status byte of a serial NOR flash slave and rules on every decoded command, deciding whether it may run. It holds the busy flag, the write-enable latch, a three-bit protection level, a status-guard bit and a one-time seal for the OTP sector. The guard bit and the seal share status bit 7: the seal is shown while the OTP-mode input is high. The command decoder in front of it hands over one command code per strobe, together with the target address, the data byte for a status write, the level of the hardware guard pin and the OTP-mode flag.

The block answers each command with an accept or a reject pulse one cycle after the strobe, and applies the resulting state change on the same edge. An accepted program, erase or status write sets the busy flag. The flag stays set until the array sequencer returns its cycle-done strobe. The protection level is decoded into a per-block protect mask over a power-of-two number of equal blocks, and the top part of the array is the part it protects. Serial shifting and the memory array itself are handled elsewhere.

Top module: `flash_status_guard`

## Requirements
- R1: The status byte holds the busy flag in bit 0, the write-enable latch in bit 1, the protection level in bits 4:2 (bit 4 is the most significant), zeros in bits 6:5, and in bit 7 the status-guard bit, or the OTP seal while otp_mode is 1. After reset the byte reads 8'h00.
- R2: Code 0 sets the write-enable latch and code 1 clears it. Both are accepted whenever the busy flag is clear.
- R3: A status write (code 2), program (3), sector erase (4), block erase (5) or chip erase (6) is rejected while the write-enable latch is 0.
- R4: Block b of the NBLK blocks (NBLK is 8 by default, block index = the top address bits) is protected when: level bit 4 = 1, protecting all blocks; level 3 protects the upper half; level 2 protects the upper quarter; level 1 protects the top block; level 0 protects none.
- R5: A program, sector erase or block erase whose target block is protected is rejected. A chip erase is accepted only when the protection level is 0. A rejected command leaves the latch unchanged.
- R6: Outside OTP mode, a status write is rejected when the guard bit is 1 and hw_guard_n is 0.
- R7: An accepted status write outside OTP mode loads data bit 7 into the guard bit and data bits 4:2 into the level. Data bits 6, 5, 1 and 0 have no effect.
- R8: In OTP mode an accepted status write ignores its data and sets the seal. The seal never clears. With the seal set in OTP mode, program and all erases are rejected. In OTP mode, program and erase ignore the protection level.
- R9: An accepted status write, program or erase sets the busy flag. cycle_done while busy clears both the busy flag and the latch; cycle_done while idle has no effect.
- R10: While busy, every command with codes 0 to 7 (including array read, code 7) is rejected, and the busy flag stays set until cycle_done.
- R11: For codes 0 to 7, exactly one of accept_o and reject_o pulses in the cycle after cmd_valid. Codes 8 to 15 give neither pulse and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 4 | Command code (R11) |
| cmd_addr | input | ADDR_W | Target byte address |
| wrsr_data | input | 8 | Data byte for a status write |
| hw_guard_n | input | 1 | Hardware guard pin, low = guard armed |
| otp_mode | input | 1 | OTP sector mode flag |
| cycle_done | input | 1 | End of program, erase or status-write cycle |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | Command accepted, one cycle after the strobe |
| reject_o | output | 1 | Command rejected, one cycle after the strobe |

## Verification
Several rules are checked by assertions on every cycle: the reserved bits read zero, a busy cycle never starts without the latch, the end of a cycle clears busy and latch together, the seal is sticky, and the protected blocks always form a contiguous top range. The same always-on checks force a rejection for a guarded status write, for a chip erase under a non-zero level and for any command while busy. Other behaviour shows only in the bench's scenarios: the exact status values after each write, that the data bits are masked, that a status write in OTP mode ignores its data, and the accept or reject outcome for each of the 64 pairs of level and target block.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [3:0] {
    OP_WEN_SET   = 4'd0,
    OP_WEN_CLR   = 4'd1,
    OP_STAT_WR   = 4'd2,
    OP_PROG      = 4'd3,
    OP_ERASE_SEC = 4'd4,
    OP_ERASE_BLK = 4'd5,
    OP_ERASE_ALL = 4'd6,
    OP_ARRAY_RD  = 4'd7
  } op_e;

  localparam int unsigned LVL_W = 3;

  // Number of guarded blocks, counted from the top of the array.
  function automatic int unsigned guarded_count(input logic [LVL_W-1:0] lvl,
                                                input int unsigned nblk);
    if (lvl[LVL_W-1])      return nblk;
    else if (lvl == '0)    return 0;
    else                   return nblk >> (4 - int'(lvl));
  endfunction

  function automatic logic is_known(input logic [3:0] code);
    return code <= 4'd7;
  endfunction

  function automatic logic starts_cycle(input op_e op);
    return (op == OP_STAT_WR) || (op == OP_PROG) || (op == OP_ERASE_SEC) ||
           (op == OP_ERASE_BLK) || (op == OP_ERASE_ALL);
  endfunction

endpackage

// File: rtl/fsg_protect_map.sv
module fsg_protect_map
  import fsg_pkg::*;
#(
  parameter int unsigned NBLK = 8
) (
  input  logic [LVL_W-1:0] lvl_i,
  output logic [NBLK-1:0]  blk_prot_o
);

  int unsigned guard_n;
  assign guard_n = guarded_count(lvl_i, NBLK);

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk_prot_o[b] = (b >= int'(NBLK) - int'(guard_n));
  end

endmodule

// File: rtl/fsg_cmd_judge.sv
module fsg_cmd_judge
  import fsg_pkg::*;
(
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_code_i,
  input  logic             target_prot_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             busy_i,
  input  logic             wen_i,
  input  logic             guard_i,
  input  logic             seal_i,
  input  logic             hw_guard_n_i,
  input  logic             otp_mode_i,
  output logic             known_o,
  output logic             ok_o,
  output logic             take_o
);

  function automatic logic decide(input op_e op, input logic busy, input logic wen,
                                  input logic tprot, input logic lvl_zero,
                                  input logic hw_locked, input logic otp,
                                  input logic seal);
    if (busy) return 1'b0;
    case (op)
      OP_WEN_SET, OP_WEN_CLR, OP_ARRAY_RD: return 1'b1;
      OP_STAT_WR:   return wen && (otp || !hw_locked);
      OP_PROG, OP_ERASE_SEC, OP_ERASE_BLK:
                    return wen && !(otp ? seal : tprot);
      OP_ERASE_ALL: return wen && lvl_zero && !(otp && seal);
      default:      return 1'b0;
    endcase
  endfunction

  op_e  op;
  logic hw_locked;

  assign op        = op_e'(cmd_code_i);
  assign hw_locked = guard_i && !hw_guard_n_i;
  assign known_o   = cmd_valid_i && is_known(cmd_code_i);
  assign ok_o      = known_o && decide(op, busy_i, wen_i, target_prot_i,
                                       (lvl_i == '0), hw_locked, otp_mode_i, seal_i);
  assign take_o    = cmd_valid_i;

endmodule

// File: rtl/fsg_status_core.sv
module fsg_status_core
  import fsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ok_i,
  input  logic [3:0]       cmd_code_i,
  input  logic             new_guard_i,
  input  logic [LVL_W-1:0] new_lvl_i,
  input  logic             otp_mode_i,
  input  logic             cycle_done_i,
  output logic             busy_o,
  output logic             wen_o,
  output logic             guard_o,
  output logic             seal_o,
  output logic [LVL_W-1:0] lvl_o
);

  logic             busy_q, wen_q, guard_q, seal_q;
  logic [LVL_W-1:0] lvl_q;
  op_e              op;
  logic             cycle_end;

  assign op        = op_e'(cmd_code_i);
  assign cycle_end = cycle_done_i && busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wen_q   <= 1'b0;
      guard_q <= 1'b0;
      seal_q  <= 1'b0;
      lvl_q   <= '0;
    end else begin
      if (cycle_end) begin
        busy_q <= 1'b0;
        wen_q  <= 1'b0;
      end
      if (ok_i) begin
        if (starts_cycle(op)) busy_q <= 1'b1;
        case (op)
          OP_WEN_SET: wen_q <= 1'b1;
          OP_WEN_CLR: wen_q <= 1'b0;
          OP_STAT_WR: begin
            if (otp_mode_i) seal_q <= 1'b1;
            else begin
              guard_q <= new_guard_i;
              lvl_q   <= new_lvl_i;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o  = busy_q;
  assign wen_o   = wen_q;
  assign guard_o = guard_q;
  assign seal_o  = seal_q;
  assign lvl_o   = lvl_q;

  AST_WEN_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wen_q)); // R3
  AST_END_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> (!busy_q && !wen_q)); // R9
  AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seal_q |=> seal_q); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cycle_done_i) |=> busy_q); // R10

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned BLOCK_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        wrsr_data,
  input  logic              hw_guard_n,
  input  logic              otp_mode,
  input  logic              cycle_done,
  output logic [7:0]        status_o,
  output logic              accept_o,
  output logic              reject_o
);

  localparam int unsigned BLK_IDX_W = ADDR_W - BLOCK_AW;
  localparam int unsigned NBLK      = 1 << BLK_IDX_W;

  logic [BLK_IDX_W-1:0] blk_idx;
  logic [NBLK-1:0]      blk_prot;
  logic                 target_prot;
  logic                 known, ok, take;
  logic                 busy, wen, guard, seal;
  logic [LVL_W-1:0]     lvl;
  logic                 acc_q, rej_q;
  logic                 unused_bits;

  assign blk_idx     = cmd_addr[ADDR_W-1:BLOCK_AW];
  assign target_prot = blk_prot[blk_idx];
  assign unused_bits = ^{cmd_addr[BLOCK_AW-1:0], wrsr_data[6:5], wrsr_data[1:0], take};

  fsg_protect_map #(.NBLK(NBLK)) u_map (
    .lvl_i      (lvl),
    .blk_prot_o (blk_prot)
  );

  fsg_cmd_judge u_judge (
    .cmd_valid_i   (cmd_valid),
    .cmd_code_i    (cmd_code),
    .target_prot_i (target_prot),
    .lvl_i         (lvl),
    .busy_i        (busy),
    .wen_i         (wen),
    .guard_i       (guard),
    .seal_i        (seal),
    .hw_guard_n_i  (hw_guard_n),
    .otp_mode_i    (otp_mode),
    .known_o       (known),
    .ok_o          (ok),
    .take_o        (take)
  );

  fsg_status_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .ok_i         (ok),
    .cmd_code_i   (cmd_code),
    .new_guard_i  (wrsr_data[7]),
    .new_lvl_i    (wrsr_data[4:2]),
    .otp_mode_i   (otp_mode),
    .cycle_done_i (cycle_done),
    .busy_o       (busy),
    .wen_o        (wen),
    .guard_o      (guard),
    .seal_o       (seal),
    .lvl_o        (lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= ok;
      rej_q <= known && !ok;
    end
  end

  assign status_o = {(otp_mode ? seal : guard), 2'b00, lvl, wen, busy};
  assign accept_o = acc_q;
  assign reject_o = rej_q;

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:5] == 2'b00); // R1
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && reject_o)); // R11
  AST_HW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_STAT_WR && !otp_mode && guard && !hw_guard_n)
      |=> reject_o); // R6
  AST_FULL_ERASE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_ERASE_ALL && lvl != '0) |=> reject_o); // R5
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (known && busy) |=> reject_o); // R10

  for (genvar b = 1; b < NBLK; b++) begin : g_top_range
    AST_MAP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      blk_prot[b-1] |-> blk_prot[b]); // R4
  end

endmodule

// File: tb/flash_status_guard_test.sv
module flash_status_guard_test;

  localparam logic [3:0] C_SET = 4'd0, C_CLR = 4'd1, C_SWR = 4'd2, C_PRG = 4'd3,
                         C_ESE = 4'd4, C_EBL = 4'd5, C_EAL = 4'd6, C_RD  = 4'd7,
                         C_BAD = 4'hF, C_NOP = 4'hE;

  typedef struct packed {
    logic [3:0]  op;
    logic [18:0] addr;
    logic [7:0]  data;
    logic        hg;
    logic        otp;
    logic        done;
    logic        acc;
    logic        rej;
    logic [7:0]  st;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 60;
  localparam vec_t TBL [NV] = '{
    '{C_PRG, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 4'd3},  // R3
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 4'd2},  // R2
    '{C_CLR, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'd2},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 4'd2},
    '{C_SWR, 19'h00000, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h9F, 4'd7},  // R7
    '{C_RD,  19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h9F, 4'd10}, // R10
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h9F, 4'd10},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h9C, 4'd9},  // R9
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h9E, 4'd2},
    '{C_SWR, 19'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h9E, 4'd6},  // R6
    '{C_SWR, 19'h00000, 8'h67, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07, 4'd7},  // R7 masked bits
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h04, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h06, 4'd2},
    '{C_PRG, 19'h70000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h06, 4'd5},  // R5
    '{C_ESE, 19'h6F000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07, 4'd4},  // R4
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h04, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h06, 4'd2},
    '{C_EAL, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h06, 4'd5},
    '{C_SWR, 19'h00000, 8'h08, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0B, 4'd7},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h08, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0A, 4'd2},
    '{C_EBL, 19'h60000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0A, 4'd4},
    '{C_PRG, 19'h5FFFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0B, 4'd4},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h08, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0A, 4'd2},
    '{C_SWR, 19'h00000, 8'h0C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0F, 4'd7},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0C, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0E, 4'd2},
    '{C_PRG, 19'h40000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0E, 4'd4},
    '{C_PRG, 19'h3FFFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0F, 4'd4},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0C, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0E, 4'd2},
    '{C_SWR, 19'h00000, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h13, 4'd7},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h10, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12, 4'd2},
    '{C_PRG, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 4'd4},
    '{C_SWR, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03, 4'd7},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 4'd2},
    '{C_EAL, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03, 4'd5},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9},
    '{C_BAD, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd11}, // R11
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9},  // idle done
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02, 4'd8},  // R8
    '{C_PRG, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h03, 4'd8},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02, 4'd2},
    '{C_SWR, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h83, 4'd8},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h80, 4'd9},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h82, 4'd2},
    '{C_ESE, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h82, 4'd8},
    '{C_EAL, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h82, 4'd8},
    '{C_CLR, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 4'd2},
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 4'd1},  // R1 bit7 = guard
    '{C_SWR, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03, 4'd7},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 4'd8},  // seal survives
    '{C_SET, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 4'd2},
    '{C_PRG, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03, 4'd9},
    '{C_NOP, 19'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_code = 4'd0;
  logic [18:0] cmd_addr = '0;
  logic [7:0]  wrsr_data = 8'h00;
  logic        hw_guard_n = 1'b1;
  logic        otp_mode = 1'b0;
  logic        cycle_done = 1'b0;
  logic [7:0]  status_o;
  logic        accept_o, reject_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_status_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .wrsr_data(wrsr_data), .hw_guard_n(hw_guard_n),
    .otp_mode(otp_mode), .cycle_done(cycle_done), .status_o(status_o),
    .accept_o(accept_o), .reject_o(reject_o)
  );

  function automatic bit bench_guarded(input int lvl, input int blk);
    if (lvl >= 4) return 1'b1;
    case (lvl)
      3: return blk >= 4;
      2: return blk >= 6;
      1: return blk == 7;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s acc/rej/status got %b_%b_%h expected %b_%b_%h", req,
               got[9], got[8], got[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [18:0] a, input logic [7:0] d,
                      input logic done);
    @(negedge clk);
    cmd_valid  = (op != C_NOP);
    cmd_code   = op;
    cmd_addr   = a;
    wrsr_data  = d;
    cycle_done = done;
    @(negedge clk);
    cmd_valid  = 1'b0;
    cycle_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {accept_o, reject_o, status_o}, {2'b00, 8'h00});

    for (int i = 0; i < NV; i++) begin
      hw_guard_n = TBL[i].hg;
      otp_mode   = TBL[i].otp;
      step(TBL[i].op, TBL[i].addr, TBL[i].data, TBL[i].done);
      check($sformatf("R%0d vec %0d", TBL[i].req, i), {accept_o, reject_o, status_o},
            {TBL[i].acc, TBL[i].rej, TBL[i].st});
    end

    // R4 R5: sweep every level against every block with a program
    hw_guard_n = 1'b1;
    otp_mode   = 1'b0;
    for (int lv = 0; lv < 8; lv++) begin
      step(C_SET, 19'h0, 8'h00, 1'b0);
      step(C_SWR, 19'h0, 8'(lv << 2), 1'b0);
      step(C_NOP, 19'h0, 8'h00, 1'b1);
      for (int bk = 0; bk < 8; bk++) begin
        bit exp_ok;
        exp_ok = !bench_guarded(lv, bk);
        step(C_SET, 19'h0, 8'h00, 1'b0);
        step(C_PRG, 19'((bk << 16) | 32'h123), 8'h00, 1'b0);
        check($sformatf("R4 level %0d block %0d", lv, bk),
              {accept_o, reject_o, status_o},
              {exp_ok, !exp_ok, 3'b000, 3'(lv), 1'b1, exp_ok});
        if (exp_ok) step(C_NOP, 19'h0, 8'h00, 1'b1);
        else        step(C_CLR, 19'h0, 8'h00, 1'b0);
      end
    end

    // R1: reset returns the byte to zero from a loaded state
    step(C_SET, 19'h0, 8'h00, 1'b0);
    step(C_SWR, 19'h0, 8'h9C, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset after load", {accept_o, reject_o, status_o}, {2'b00, 8'h00});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule